// File: doc/BRIEF.md
# FIFO Retransmit Controller

This block sits on the read side of a synchronous FIFO and lets the reader replay data it has already consumed. It owns the read pointer that addresses the memory array and the read strobe that goes to it. It also owns the empty indication used in standard mode and the output-ready indication used in first-word-fall-through (prefetch) mode. The memory array, the write-side logic and the flag threshold comparators live elsewhere. The write side supplies the number of words written since reset, already brought into the read clock domain.

A retransmit request is an active-low pulse sampled on a rising read-clock edge. A request is taken only when both enables are idle, no setup is already running and the word count lies inside the legal window. A taken request resets the pointer to the first memory location and starts a fixed setup phase. During that phase the empty flag is held low in standard mode and output-ready is held inactive in prefetch mode. In prefetch mode the word at address zero is fetched on the last setup cycle, so it sits on the outputs when setup ends without any read enable.

The block emits three one-cycle update strobes for the flag comparators, each timed to the edge on which that flag must re-evaluate. The almost-full strobe is carried into the write-clock domain by a toggle synchronizer. An out-of-window request is dropped and reported with an error pulse.

Top module: `fifo_rtx_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no words written: `empty_n_o`=0, `nrdy_o`=1, `mem_re_o`=0, `rd_addr_o`=0, and all strobes (`rt_err_o`, `hf_upd_o`, `ae_upd_o`, `af_upd_o`) are 0.
- R2: In standard mode (`fwft_i`=0), outside setup, `mem_re_o` is 1 exactly when `ren_n_i`=0 and fewer words have been fetched than `wr_total_i`. `rd_addr_o` gives the fetch count modulo DEPTH and advances by one per fetch. In both modes, `empty_n_o`=1 exactly when no setup is running and fetched words < `wr_total_i`.
- R3: In prefetch mode (`fwft_i`=1), a word is fetched without `ren_n_i` when the output holder is empty and data remain. `nrdy_o` goes 0 on the edge that fetches. Each further word needs `ren_n_i`=0 while `nrdy_o`=0. `nrdy_o` returns to 1 when the held word is consumed and nothing remains.
- R4: A retransmit is taken on a rising `rclk_i` edge when `rt_n_i`=0, `ren_n_i`=1, `wen_n_i`=1, no setup is running and the count rule holds. After that edge `rd_addr_o`=0.
- R5: In standard mode, `empty_n_o` is 0 for SETUP_CYC cycles after the taken edge, and `ren_n_i` has no effect then (`mem_re_o`=0). Afterwards `empty_n_o`=1, and the first replayed word (address 0) needs `ren_n_i`=0.
- R6: In prefetch mode, `nrdy_o`=1 during setup. On the last setup cycle `mem_re_o`=1 with `rd_addr_o`=0, and `nrdy_o` falls on the edge that ends setup. Later words need `ren_n_i`=0.
- R7: The count rule is 1 <= `wr_total_i` <= DEPTH-2 in standard mode and 1 <= `wr_total_i` <= DEPTH-1 in prefetch mode. A request that is otherwise acceptable but breaks the rule leaves the pointer unchanged and sets `rt_err_o`=1 for exactly the cycle after its edge.
- R8: A request with `ren_n_i`=0 or `wen_n_i`=0, or one made during setup, is ignored. No strobe is produced, no error is raised and reading proceeds as if `rt_n_i` were 1.
- R9: `hf_upd_o` is 1 for exactly the cycle after the taken edge, so the half-full flag re-evaluates on that edge.
- R10: `ae_upd_o` is 1 for exactly the cycle after the edge that ends setup, which is the second read-clock edge after the taken edge when SETUP_CYC=2.
- R11: `af_upd_o` is a one-write-cycle pulse that rises on the second `wclk_i` edge after the taken read-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk_i | input | 1 | Read clock |
| wclk_i | input | 1 | Write clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| fwft_i | input | 1 | 1 selects prefetch mode, 0 standard mode; changed only in reset |
| rt_n_i | input | 1 | Active-low retransmit request |
| ren_n_i | input | 1 | Active-low read enable |
| wen_n_i | input | 1 | Active-low write enable, sampled on the read clock for the request check |
| wr_total_i | input | AW+1 | Words written since reset, read-clock domain |
| rd_addr_o | output | AW | Memory read address |
| mem_re_o | output | 1 | Memory read strobe; data appear after the next rising read-clock edge |
| empty_n_o | output | 1 | Empty flag, 0 means nothing to read or setup running |
| nrdy_o | output | 1 | Output-ready flag for prefetch mode, 1 means no word held |
| rt_err_o | output | 1 | One-cycle pulse for a request rejected by the count rule |
| hf_upd_o | output | 1 | Half-full update strobe, read-clock domain |
| ae_upd_o | output | 1 | Almost-empty update strobe, read-clock domain |
| af_upd_o | output | 1 | Almost-full update strobe, write-clock domain |

## Verification
The bench builds the block with DEPTH=16 and SETUP_CYC=2. A depth of 16 puts both count-rule limits (14 words in standard mode, 15 in prefetch mode) within a few writes, so random runs cross the accepted and rejected sides of the window often. A two-cycle setup makes the almost-empty strobe land on the second edge, as the schedule requires. The write clock runs at the read clock's frequency with a fixed quarter-period phase offset, which makes the second-write-edge timing of the almost-full strobe an exact, checkable instant.

// File: rtl/rtx_pkg.sv
`timescale 1ns/1ps
package rtx_pkg;

  // Outcome of qualifying a retransmit request on one read-clock edge.
  typedef struct packed {
    logic go;   // request taken: pointer home, setup starts
    logic err;  // request well-formed but outside the word-count window
  } rtx_req_t;

  // Largest word count for which a retransmit is legal.
  function automatic int rtx_limit(input int depth, input logic fwft);
    return fwft ? depth - 1 : depth - 2;
  endfunction

endpackage

// File: rtl/rtx_rst_sync.sv
`timescale 1ns/1ps
module rtx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rtx_req_qual.sv
`timescale 1ns/1ps
module rtx_req_qual import rtx_pkg::*; #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          in_setup_i,
  input  logic          fwft_i,
  input  logic          rt_n_i,
  input  logic          ren_n_i,
  input  logic          wen_n_i,
  input  logic [CW-1:0] wr_total_i,
  output rtx_req_t      req_o
);

  localparam logic [CW:0] LIM_STD  = (CW+1)'(rtx_limit(DEPTH, 1'b0));
  localparam logic [CW:0] LIM_FWFT = (CW+1)'(rtx_limit(DEPTH, 1'b1));

  logic          asked;
  logic          in_window;
  logic [CW:0]   limit;

  always_comb begin
    asked     = !in_setup_i && !rt_n_i && ren_n_i && wen_n_i;
    limit     = fwft_i ? LIM_FWFT : LIM_STD;
    in_window = (wr_total_i != '0) && ({1'b0, wr_total_i} <= limit);
    req_o.go  = asked && in_window;
    req_o.err = asked && !in_window;
  end

endmodule

// File: rtl/rtx_rd_ctrl.sv
`timescale 1ns/1ps
module rtx_rd_ctrl import rtx_pkg::*; #(
  parameter  int DEPTH     = 1024,
  parameter  int SETUP_CYC = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = AW + 1,
  localparam int SW        = $clog2(SETUP_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          fwft_i,
  input  logic          ren_n_i,
  input  logic [CW-1:0] wr_total_i,
  input  rtx_req_t      req_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          mem_re_o,
  output logic          empty_n_o,
  output logic          nrdy_o,
  output logic          in_setup_o,
  output logic          setup_end_o
);

  logic [CW-1:0] rd_q, rd_d;
  logic [SW-1:0] rem_q, rem_d;
  logic          held_q, held_d;
  logic          rd_en, rem_en, held_en;
  logic          avail, in_setup, last_setup;
  logic          std_rd, pf_fetch, pf_take;

  always_comb begin
    avail      = (rd_q != wr_total_i);
    in_setup   = (rem_q != '0);
    last_setup = (rem_q == SW'(1));
  end

  // Next-state logic: retransmit has priority, setup freezes the reader.
  always_comb begin
    rd_d     = rd_q;
    rem_d    = rem_q;
    held_d   = held_q;
    std_rd   = 1'b0;
    pf_fetch = 1'b0;
    pf_take  = 1'b0;
    if (req_i.go) begin
      rd_d   = '0;
      rem_d  = SW'(SETUP_CYC);
      held_d = 1'b0;
    end else if (in_setup) begin
      rem_d    = rem_q - SW'(1);
      pf_fetch = fwft_i && last_setup && avail;
    end else if (fwft_i) begin
      pf_take  = held_q && !ren_n_i;
      pf_fetch = avail && (!held_q || pf_take);
    end else begin
      std_rd = !ren_n_i && avail;
    end
    if (pf_fetch)     held_d = 1'b1;
    else if (pf_take) held_d = 1'b0;
    if (pf_fetch || std_rd) rd_d = rd_q + CW'(1);
  end

  always_comb begin
    rd_en   = req_i.go || pf_fetch || std_rd;
    rem_en  = req_i.go || in_setup;
    held_en = req_i.go || pf_fetch || pf_take;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rd_q   <= '0;
      rem_q  <= '0;
      held_q <= 1'b0;
    end else begin
      if (rd_en)   rd_q   <= rd_d;
      if (rem_en)  rem_q  <= rem_d;
      if (held_en) held_q <= held_d;
    end
  end

  assign rd_addr_o   = rd_q[AW-1:0];
  assign mem_re_o    = std_rd || pf_fetch;
  assign empty_n_o   = !in_setup && avail;
  assign nrdy_o      = !held_q;
  assign in_setup_o  = in_setup;
  assign setup_end_o = last_setup;

endmodule

// File: rtl/rtx_flag_sched.sv
`timescale 1ns/1ps
module rtx_flag_sched import rtx_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic     rclk_i,
  input  logic     rrst_n_i,
  input  logic     wclk_i,
  input  logic     wrst_n_i,
  input  rtx_req_t req_i,
  input  logic     setup_end_i,
  output logic     hf_upd_o,
  output logic     ae_upd_o,
  output logic     err_o,
  output logic     af_upd_o
);

  logic hf_q, ae_q, err_q, tog_q, tog_d;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic hist_q;

  always_comb begin
    tog_d  = tog_q ^ req_i.go;
    sync_d = {sync_q[SYNC_STAGES-2:0], tog_q};
  end

  // Read-clock strobes and the crossing toggle.
  always_ff @(posedge rclk_i or negedge rrst_n_i) begin
    if (!rrst_n_i) begin
      hf_q  <= 1'b0;
      ae_q  <= 1'b0;
      err_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      hf_q  <= req_i.go;
      ae_q  <= setup_end_i;
      err_q <= req_i.err;
      if (req_i.go) tog_q <= tog_d;
    end
  end

  // Write-clock synchronizer and edge detector.
  always_ff @(posedge wclk_i or negedge wrst_n_i) begin
    if (!wrst_n_i) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign hf_upd_o = hf_q;
  assign ae_upd_o = ae_q;
  assign err_o    = err_q;
  assign af_upd_o = sync_q[SYNC_STAGES-1] ^ hist_q;

endmodule

// File: rtl/fifo_rtx_ctrl.sv
`timescale 1ns/1ps
module fifo_rtx_ctrl import rtx_pkg::*; #(
  parameter  int DEPTH       = 1024,
  parameter  int SETUP_CYC   = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH),
  localparam int CW          = AW + 1
) (
  input  logic          rclk_i,
  input  logic          wclk_i,
  input  logic          rst_n_i,
  input  logic          fwft_i,
  input  logic          rt_n_i,
  input  logic          ren_n_i,
  input  logic          wen_n_i,
  input  logic [CW-1:0] wr_total_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          mem_re_o,
  output logic          empty_n_o,
  output logic          nrdy_o,
  output logic          rt_err_o,
  output logic          hf_upd_o,
  output logic          ae_upd_o,
  output logic          af_upd_o
);

  logic     rrst_n, wrst_n;
  logic     in_setup, setup_end;
  rtx_req_t req;

  rtx_rst_sync #(.STAGES(2)) u_rrst (
    .clk_i(rclk_i), .rst_n_i(rst_n_i), .rst_n_o(rrst_n)
  );

  rtx_rst_sync #(.STAGES(2)) u_wrst (
    .clk_i(wclk_i), .rst_n_i(rst_n_i), .rst_n_o(wrst_n)
  );

  rtx_req_qual #(.DEPTH(DEPTH)) u_qual (
    .in_setup_i (in_setup),
    .fwft_i     (fwft_i),
    .rt_n_i     (rt_n_i),
    .ren_n_i    (ren_n_i),
    .wen_n_i    (wen_n_i),
    .wr_total_i (wr_total_i),
    .req_o      (req)
  );

  rtx_rd_ctrl #(.DEPTH(DEPTH), .SETUP_CYC(SETUP_CYC)) u_rd (
    .clk_i       (rclk_i),
    .rst_n_i     (rrst_n),
    .fwft_i      (fwft_i),
    .ren_n_i     (ren_n_i),
    .wr_total_i  (wr_total_i),
    .req_i       (req),
    .rd_addr_o   (rd_addr_o),
    .mem_re_o    (mem_re_o),
    .empty_n_o   (empty_n_o),
    .nrdy_o      (nrdy_o),
    .in_setup_o  (in_setup),
    .setup_end_o (setup_end)
  );

  rtx_flag_sched #(.SYNC_STAGES(SYNC_STAGES)) u_flags (
    .rclk_i      (rclk_i),
    .rrst_n_i    (rrst_n),
    .wclk_i      (wclk_i),
    .wrst_n_i    (wrst_n),
    .req_i       (req),
    .setup_end_i (setup_end),
    .hf_upd_o    (hf_upd_o),
    .ae_upd_o    (ae_upd_o),
    .err_o       (rt_err_o),
    .af_upd_o    (af_upd_o)
  );

endmodule

// File: rtl/fifo_rtx_ctrl_chk.sv
`timescale 1ns/1ps
module fifo_rtx_ctrl_chk #(
  parameter  int DEPTH     = 1024,
  parameter  int SETUP_CYC = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int CW        = AW + 1
) (
  input logic          rclk_i,
  input logic          rst_n_i,
  input logic          fwft_i,
  input logic          ren_n_i,
  input logic [CW-1:0] wr_total_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          mem_re_o,
  input logic          empty_n_o,
  input logic          nrdy_o,
  input logic          rt_err_o,
  input logic          hf_upd_o,
  input logic          ae_upd_o
);

  p_std_needs_ren_r2: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    (mem_re_o && !fwft_i) |-> !ren_n_i);

  p_fetch_in_range_r2: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    mem_re_o |-> ({1'b0, rd_addr_o} < wr_total_i));

  p_ptr_home_r4: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    hf_upd_o |-> (rd_addr_o == '0));

  p_setup_empty_r5: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    (hf_upd_o && !fwft_i) |-> (!empty_n_o && !mem_re_o));

  p_setup_done_empty_r5: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    (ae_upd_o && !fwft_i) |-> empty_n_o);

  p_setup_nrdy_r6: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    hf_upd_o |-> nrdy_o);

  p_setup_done_ready_r6: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    (ae_upd_o && fwft_i) |-> !nrdy_o);

  p_err_excl_r7: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    rt_err_o |-> !hf_upd_o);

  p_hf_single_r9: assert property (@(posedge rclk_i) disable iff (!rst_n_i)
    hf_upd_o |=> !hf_upd_o);

endmodule

bind fifo_rtx_ctrl fifo_rtx_ctrl_chk #(.DEPTH(DEPTH), .SETUP_CYC(SETUP_CYC)) u_chk (.*);

// File: tb/fifo_rtx_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_rtx_ctrl_tb_top;

  localparam int DEPTH = 16;
  localparam int SC    = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;

  logic rclk = 1'b0;
  logic wclk = 1'b0;
  logic rst_n, fwft, rt_n, ren_n, wen_n;
  logic [CW-1:0] wt;
  logic [AW-1:0] rd_addr;
  logic mem_re, empty_n, nrdy, rt_err, hf_upd, ae_upd, af_upd;

  int n_vec = 0;
  int n_bad = 0;
  int wcap  = DEPTH - 1;
  bit ended = 1'b0;

  // bench model state
  int m_rd, m_set;
  bit m_v, m_hf, m_ae, m_err;

  always #10 rclk = ~rclk;
  initial begin
    #5;
    forever #10 wclk = ~wclk;
  end

  fifo_rtx_ctrl #(.DEPTH(DEPTH), .SETUP_CYC(SC)) dut_i (
    .rclk_i(rclk), .wclk_i(wclk), .rst_n_i(rst_n), .fwft_i(fwft),
    .rt_n_i(rt_n), .ren_n_i(ren_n), .wen_n_i(wen_n), .wr_total_i(wt),
    .rd_addr_o(rd_addr), .mem_re_o(mem_re), .empty_n_o(empty_n),
    .nrdy_o(nrdy), .rt_err_o(rt_err), .hf_upd_o(hf_upd),
    .ae_upd_o(ae_upd), .af_upd_o(af_upd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int limit_of(input bit pf);
    return pf ? DEPTH - 1 : DEPTH - 2;
  endfunction

  // One read cycle: drive, check against the model, advance over the edge.
  task automatic step(input logic rtn, input logic rn, input logic wn);
    bit av, req, rule, go, rd, take, fet;
    rt_n = rtn; ren_n = rn; wen_n = wn;
    #1;
    av   = (m_rd != int'(wt));
    req  = (m_set == 0) && !rtn && rn && wn;
    rule = (wt >= 1) && (int'(wt) <= limit_of(fwft));
    go   = req && rule;
    rd   = !fwft && (m_set == 0) && !rn && av;
    take = fwft && (m_set == 0) && m_v && !rn;
    fet  = fwft && !go && av && (((m_set == 0) && (!m_v || take)) || (m_set == 1));
    chk(fwft ? "R3 R6 mem_re" : "R2 R5 mem_re", int'(mem_re), int'(rd || fet));
    if (rd || fet) chk("R2 R3 rd_addr", int'(rd_addr), m_rd % DEPTH);
    chk("R2 R5 empty_n", int'(empty_n), int'((m_set == 0) && av));
    chk("R3 R6 nrdy", int'(nrdy), int'(!m_v));
    chk("R9 hf_upd", int'(hf_upd), int'(m_hf));
    chk("R10 ae_upd", int'(ae_upd), int'(m_ae));
    chk("R7 rt_err", int'(rt_err), int'(m_err));
    if (m_hf) chk("R4 pointer home", int'(rd_addr), 0);
    m_ae  = (m_set == 1);
    m_hf  = go;
    m_err = req && !rule;
    if (go) begin
      m_rd = 0; m_v = 1'b0; m_set = SC;
    end else begin
      if (rd || fet) m_rd++;
      if (m_set > 0) m_set--;
      if (fet) m_v = 1'b1;
      else if (take) m_v = 1'b0;
    end
    @(posedge rclk);
    @(negedge rclk);
    if (!wn && int'(wt) < wcap) wt = wt + CW'(1);
  endtask

  task automatic do_reset(input bit pf);
    rst_n = 1'b0; fwft = pf; rt_n = 1'b1; ren_n = 1'b1; wen_n = 1'b1; wt = '0;
    wcap = DEPTH - 1;
    repeat (3) @(negedge rclk);
    chk("R1 empty_n in reset", int'(empty_n), 0);
    chk("R1 nrdy in reset", int'(nrdy), 1);
    chk("R1 rd_addr in reset", int'(rd_addr), 0);
    chk("R1 strobes in reset", int'({rt_err, hf_upd, ae_upd, af_upd, mem_re}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge rclk);
    chk("R1 empty_n after reset", int'(empty_n), 0);
    chk("R1 nrdy after reset", int'(nrdy), 1);
    m_rd = 0; m_set = 0; m_v = 1'b0; m_hf = 1'b0; m_ae = 1'b0; m_err = 1'b0;
  endtask

  task automatic af_window(input string tag);
    chk({tag, " af before second wclk edge"}, int'(af_upd), 0);
    step(1'b1, 1'b1, 1'b1);
    chk({tag, " af after second wclk edge"}, int'(af_upd), 1);
    step(1'b1, 1'b1, 1'b1);
    chk({tag, " af one write cycle"}, int'(af_upd), 0);
  endtask

  initial begin
    void'($urandom(32'd7741));
    // ---------------- standard mode, directed
    do_reset(1'b0);
    step(1'b0, 1'b1, 1'b1);              // R7: no words written -> error
    chk("R7 error on zero count", int'(rt_err), 1);
    repeat (5) step(1'b1, 1'b1, 1'b0);   // write 5
    repeat (3) step(1'b1, 1'b0, 1'b1);   // read 3
    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1);              // R4 retransmit taken
    chk("R9 hf after taken edge", int'(hf_upd), 1);
    af_window("R11");
    step(1'b0, 1'b0, 1'b1);              // R8: ren low -> ignored
    chk("R8 ren low no hf", int'(hf_upd), 0);
    step(1'b0, 1'b1, 1'b0);              // R8: wen low -> ignored
    chk("R8 wen low no hf", int'(hf_upd), 0);
    chk("R8 wen low no err", int'(rt_err), 0);
    step(1'b0, 1'b1, 1'b1);              // taken
    step(1'b0, 1'b1, 1'b1);              // R8: during setup -> ignored
    chk("R8 during setup no err", int'(rt_err), 0);
    step(1'b1, 1'b0, 1'b1);              // R5: ren low in setup ignored
    repeat (8) step(1'b1, 1'b0, 1'b1);
    while (int'(wt) < DEPTH - 2) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);              // R7 boundary 14 accepted
    chk("R7 limit accepted", int'(hf_upd), 1);
    repeat (3) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);              // 15 words
    step(1'b0, 1'b1, 1'b1);              // R7 above limit
    chk("R7 above limit error", int'(rt_err), 1);
    repeat (3) step(1'b1, 1'b0, 1'b1);
    // ---------------- prefetch mode, directed
    do_reset(1'b1);
    step(1'b0, 1'b1, 1'b1);
    chk("R7 prefetch zero count error", int'(rt_err), 1);
    step(1'b1, 1'b1, 1'b0);              // one word, fetched without ren
    step(1'b1, 1'b1, 1'b1);
    chk("R3 first word ready", int'(nrdy), 0);
    repeat (3) step(1'b1, 1'b1, 1'b0);
    repeat (2) step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1);              // R6 retransmit
    af_window("R11 prefetch");
    chk("R6 word held after setup", int'(nrdy), 0);
    repeat (5) step(1'b1, 1'b0, 1'b1);
    wcap = DEPTH;
    while (int'(wt) < DEPTH - 1) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);              // 15 accepted in prefetch
    chk("R7 prefetch limit accepted", int'(hf_upd), 1);
    repeat (3) step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);              // 16 words
    step(1'b0, 1'b1, 1'b1);
    chk("R7 prefetch above limit error", int'(rt_err), 1);
    // ---------------- random phase
    for (int k = 0; k < 8; k++) begin
      do_reset(k[0]);
      for (int i = 0; i < 150; i++) begin
        logic a, b, c;
        a = (($urandom % 6) != 0);
        b = (($urandom % 2) != 0);
        c = (($urandom % 3) != 0);
        step(a, b, c);
      end
    end
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!ended) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule